// File: doc/BRIEF.md
# Extended-Real Versus Integer Comparator

This unit compares the value at the top of a floating-point register stack, held in 80-bit extended-precision format, with a signed integer operand. The integer is either 16 or 32 bits wide. Before comparing, the unit converts the integer exactly into extended-real form. It then reports the outcome as a three-bit condition code: greater, less, equal or unordered. The auxiliary flag C1 is always cleared.

The unit decodes an opcode byte and the three-bit reg field of the addressing byte. From these it picks the integer width and decides whether this is a plain compare or a compare-and-pop. On a pop it sends a strobe that marks the top register empty, and it returns the stack-top pointer advanced by one, wrapping modulo 8.

Each issued instruction yields a registered result one clock later.

Top module: `xr_int_cmp`

## Requirements
- R1: Opcode 0xDE takes the low 16 bits of `int_i` as a signed value and ignores the upper 16 bits. Opcode 0xDA takes all 32 bits as a signed value. The conversion is exact, including for -32768 and -2147483648.
- R2: `cc_o` = {C3,C2,C0} is 3'b000 when the stack top is greater than the integer, 3'b001 when it is less, 3'b100 when they are equal, and 3'b111 when the comparison is unordered.
- R3: The stack-top operand uses bit 79 as the sign, bits 78:64 as the exponent (bias 16383) and bits 63:0 as the significand, with bit 63 as the explicit integer bit. The result is 3'b111 in three cases: a NaN (exponent all ones, bit 63 set, bits 62:0 nonzero); an exponent all ones with bit 63 clear; and a nonzero exponent that is not all ones with bit 63 clear.
- R4: Negative zero and positive zero both compare equal to integer 0.
- R5: Infinities are ordered: positive infinity is greater than every integer, and negative infinity is less than every integer. A denormal (exponent zero, nonzero significand) compares by its true value.
- R6: Reg field 3 pops the stack. `tag_empty_o` pulses together with the result, and `top_o` equals `top_i`+1 modulo 8. Reg field 2 only compares: `top_o` equals `top_i` and there is no strobe.
- R7: A tag of 2'b11 means the stack top is empty. In that case the result is 3'b111 and `underflow_o` is 1. Otherwise `underflow_o` is 0.
- R8: `c1_o` is 0 with every result.
- R9: The result appears with `done_o` high in the cycle after `issue_i` is sampled. An issue with any other opcode or reg field produces no `done_o`. After reset, `done_o`, `tag_empty_o` and `top_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Instruction valid this cycle |
| opcode_i | input | 8 | Opcode byte |
| reg_i | input | 3 | Reg field of the addressing byte |
| st0_i | input | 80 | Stack-top extended-real value |
| st0_tag_i | input | 2 | Stack-top tag (2'b11 = empty) |
| int_i | input | 32 | Integer operand |
| top_i | input | 3 | Current stack-top pointer |
| done_o | output | 1 | Result valid |
| cc_o | output | 3 | Condition code {C3,C2,C0} |
| c1_o | output | 1 | Condition bit C1 |
| top_o | output | 3 | Updated stack-top pointer |
| tag_empty_o | output | 1 | Strobe: mark the stack-top register empty |
| underflow_o | output | 1 | Stack underflow (empty operand) |

## Verification
The assertions check the following on every cycle:
- the pop strobe only appears with a result;
- the pointer steps by one on a pop and is unchanged otherwise;
- underflow always comes with the unordered code;
- an idle cycle never yields a result;
- the operand class decode and the magnitude outcome are each one-hot.

The bench scenarios show what only concrete values can reveal:
- exact integer conversion at the negative extremes and 2^31-1;
- adjacent values one unit in the last place away;
- both signs of zero, infinities, denormals, quiet and signaling NaNs, and the unsupported encodings;
- the pointer wrapping from 7 to 0.

// File: rtl/xr_cmp_pkg.sv
package xr_cmp_pkg;
  localparam int EXP_W = 15;
  localparam int MAN_W = 64;
  localparam int XR_W  = 1 + EXP_W + MAN_W;
  localparam int KEY_W = EXP_W + MAN_W;

  localparam logic [2:0] CC_GT = 3'b000;
  localparam logic [2:0] CC_LT = 3'b001;
  localparam logic [2:0] CC_EQ = 3'b100;
  localparam logic [2:0] CC_UN = 3'b111;

  typedef struct packed {
    logic ok;
    logic narrow;
    logic pop;
  } dec_t;
endpackage

// File: rtl/xr_decode.sv
module xr_decode import xr_cmp_pkg::*; #(
  parameter logic [7:0] OP_NARROW = 8'hDE,
  parameter logic [7:0] OP_WIDE   = 8'hDA,
  parameter logic [2:0] REG_CMP   = 3'd2,
  parameter logic [2:0] REG_POP   = 3'd3
) (
  input  logic [7:0] opcode_i,
  input  logic [2:0] reg_i,
  output dec_t       dec_o
);
  logic op_hit, reg_hit;

  always_comb begin
    op_hit      = (opcode_i == OP_NARROW) || (opcode_i == OP_WIDE);
    reg_hit     = (reg_i == REG_CMP) || (reg_i == REG_POP);
    dec_o.ok     = op_hit && reg_hit;
    dec_o.narrow = (opcode_i == OP_NARROW);
    dec_o.pop    = (reg_i == REG_POP);
  end
endmodule

// File: rtl/xr_int_to_ext.sv
module xr_int_to_ext import xr_cmp_pkg::*; #(
  parameter int INT_W = 32
) (
  input  logic [INT_W-1:0] val_i,
  output logic             sign_o,
  output logic             zero_o,
  output logic [KEY_W-1:0] key_o
);
  localparam int IDX_W = $clog2(INT_W);
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;

  logic [INT_W-1:0] mag;
  logic [IDX_W-1:0] msb;
  logic [MAN_W-1:0] man;
  logic [EXP_W-1:0] exp_v;

  always_comb begin
    sign_o = val_i[INT_W-1];
    // two's complement magnitude; the minimum value maps to 2^(INT_W-1) unsigned
    mag    = sign_o ? (~val_i + 1'b1) : val_i;
    zero_o = (mag == '0);
    msb    = '0;
    for (int i = 0; i < INT_W; i++) begin
      if (mag[i]) msb = IDX_W'(i);
    end
    man   = {{(MAN_W-INT_W){1'b0}}, mag} << ((MAN_W - 1) - int'(msb));
    exp_v = EXP_W'(BIAS) + EXP_W'(msb);
    key_o = zero_o ? '0 : {exp_v, man};
  end
endmodule

// File: rtl/xr_classify.sv
module xr_classify import xr_cmp_pkg::*; (
  input  logic [XR_W-1:0]  x_i,
  output logic             sign_o,
  output logic             zero_o,
  output logic             unord_o,
  output logic [KEY_W-1:0] key_o
);
  logic [EXP_W-1:0] e;
  logic [MAN_W-1:0] m;
  logic is_zero, is_den, is_norm, is_inf, is_nan, is_bad;

  always_comb begin
    sign_o  = x_i[XR_W-1];
    e       = x_i[KEY_W-1:MAN_W];
    m       = x_i[MAN_W-1:0];
    is_zero = (e == '0) && (m == '0);
    is_den  = (e == '0) && (m != '0);
    is_inf  = (&e) && m[MAN_W-1] && (m[MAN_W-2:0] == '0);
    is_nan  = (&e) && m[MAN_W-1] && (m[MAN_W-2:0] != '0);
    // unnormal, pseudo-infinity and pseudo-NaN encodings
    is_bad  = (e != '0) && !m[MAN_W-1];
    is_norm = (e != '0) && !(&e) && m[MAN_W-1];
    zero_o  = is_zero;
    unord_o = is_nan || is_bad;
    // denormals share the scale of exponent 1, so lexicographic keys order by true value
    if (is_zero)     key_o = '0;
    else if (is_den) key_o = {EXP_W'(1), m};
    else             key_o = {e, m};
  end

  always_comb begin
    if (!$isunknown(x_i)) begin
      // R3
      class_onehot_chk: assert ($onehot({is_zero, is_den, is_norm, is_inf, is_nan, is_bad}));
    end
  end
endmodule

// File: rtl/xr_magcmp.sv
module xr_magcmp import xr_cmp_pkg::*; (
  input  logic             a_sign_i,
  input  logic             a_zero_i,
  input  logic [KEY_W-1:0] a_key_i,
  input  logic             b_sign_i,
  input  logic             b_zero_i,
  input  logic [KEY_W-1:0] b_key_i,
  output logic             gt_o,
  output logic             lt_o,
  output logic             eq_o
);
  logic sa, sb, mag_gt, mag_lt;

  always_comb begin
    // zero sign is ignored
    sa     = a_sign_i && !a_zero_i;
    sb     = b_sign_i && !b_zero_i;
    mag_gt = a_key_i > b_key_i;
    mag_lt = a_key_i < b_key_i;
    if (sa != sb) begin
      gt_o = !sa;
      lt_o = sa;
      eq_o = 1'b0;
    end else begin
      gt_o = sa ? mag_lt : mag_gt;
      lt_o = sa ? mag_gt : mag_lt;
      eq_o = !mag_gt && !mag_lt;
    end
  end

  always_comb begin
    if (!$isunknown({a_sign_i, a_zero_i, a_key_i, b_sign_i, b_zero_i, b_key_i})) begin
      // R2
      rel_onehot_chk: assert ($onehot({gt_o, lt_o, eq_o}));
    end
  end
endmodule

// File: rtl/xr_int_cmp.sv
module xr_int_cmp import xr_cmp_pkg::*; #(
  parameter int          INT_W     = 32,
  parameter int          NARROW_W  = 16,
  parameter int          TOP_W     = 3,
  parameter int          TAG_W     = 2,
  parameter logic [1:0]  TAG_EMPTY = 2'b11,
  parameter logic [7:0]  OP_NARROW = 8'hDE,
  parameter logic [7:0]  OP_WIDE   = 8'hDA,
  parameter logic [2:0]  REG_CMP   = 3'd2,
  parameter logic [2:0]  REG_POP   = 3'd3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic [7:0]       opcode_i,
  input  logic [2:0]       reg_i,
  input  logic [XR_W-1:0]  st0_i,
  input  logic [TAG_W-1:0] st0_tag_i,
  input  logic [INT_W-1:0] int_i,
  input  logic [TOP_W-1:0] top_i,
  output logic             done_o,
  output logic [2:0]       cc_o,
  output logic             c1_o,
  output logic [TOP_W-1:0] top_o,
  output logic             tag_empty_o,
  output logic             underflow_o
);
  dec_t             dec;
  logic [INT_W-1:0] int_ext;
  logic             i_sign, i_zero, s_sign, s_zero, s_unord;
  logic [KEY_W-1:0] i_key, s_key;
  logic             gt, lt, eq, empty;
  logic [2:0]       cc_d;

  xr_decode #(
    .OP_NARROW(OP_NARROW), .OP_WIDE(OP_WIDE), .REG_CMP(REG_CMP), .REG_POP(REG_POP)
  ) u_dec (
    .opcode_i(opcode_i), .reg_i(reg_i), .dec_o(dec)
  );

  always_comb begin
    int_ext = dec.narrow ? {{(INT_W-NARROW_W){int_i[NARROW_W-1]}}, int_i[NARROW_W-1:0]}
                         : int_i;
  end

  xr_int_to_ext #(.INT_W(INT_W)) u_cvt (
    .val_i(int_ext), .sign_o(i_sign), .zero_o(i_zero), .key_o(i_key)
  );

  xr_classify u_cls (
    .x_i(st0_i), .sign_o(s_sign), .zero_o(s_zero), .unord_o(s_unord), .key_o(s_key)
  );

  xr_magcmp u_cmp (
    .a_sign_i(s_sign), .a_zero_i(s_zero), .a_key_i(s_key),
    .b_sign_i(i_sign), .b_zero_i(i_zero), .b_key_i(i_key),
    .gt_o(gt), .lt_o(lt), .eq_o(eq)
  );

  always_comb begin
    empty = (st0_tag_i == TAG_EMPTY);
    if (empty || s_unord) cc_d = CC_UN;
    else if (eq)          cc_d = CC_EQ;
    else if (lt)          cc_d = CC_LT;
    else                  cc_d = CC_GT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      cc_o        <= '0;
      c1_o        <= 1'b0;
      top_o       <= '0;
      tag_empty_o <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      done_o      <= issue_i && dec.ok;
      tag_empty_o <= issue_i && dec.ok && dec.pop;
      if (issue_i && dec.ok) begin
        cc_o        <= cc_d;
        c1_o        <= 1'b0;
        underflow_o <= empty;
        top_o       <= dec.pop ? top_i + 1'b1 : top_i;
      end
    end
  end

  // R6
  strobe_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_empty_o |-> done_o);
  // R6
  pop_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && dec.ok && dec.pop) |=> (top_o == $past(top_i) + 1'b1));
  // R6
  no_pop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !tag_empty_o) |-> (top_o == $past(top_i)));
  // R7
  underflow_unord_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && underflow_o) |-> (cc_o == CC_UN));
  // R9
  idle_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> !done_o);
endmodule

// File: tb/sim_xr_int_cmp.sv
module sim_xr_int_cmp;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [2:0]  rg = 3'd0;
  logic [79:0] st0 = '0;
  logic [1:0]  tag = 2'b00;
  logic [31:0] ival = '0;
  logic [2:0]  top = '0;
  logic        done_o, c1_o, tag_empty_o, underflow_o;
  logic [2:0]  cc_o, top_o;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [2:0] cc;
    logic [2:0] top;
    logic       pop;
    logic       unf;
    string      req;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  xr_int_cmp u0 (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .opcode_i(opcode), .reg_i(rg),
    .st0_i(st0), .st0_tag_i(tag), .int_i(ival), .top_i(top),
    .done_o(done_o), .cc_o(cc_o), .c1_o(c1_o), .top_o(top_o),
    .tag_empty_o(tag_empty_o), .underflow_o(underflow_o)
  );

  function automatic logic [79:0] xr(input bit s, input bit [14:0] e, input bit [63:0] m);
    return {s, e, m};
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      n_chk++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL R9 unexpected result: actual done=1 expected done=0");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if ({cc_o, c1_o, top_o, tag_empty_o, underflow_o} !== {e.cc, 1'b0, e.top, e.pop, e.unf}) begin
          n_fail++;
          $display("FAIL %s: actual cc=%b c1=%b top=%0d pop=%b unf=%b expected cc=%b c1=0 top=%0d pop=%b unf=%b",
                   e.req, cc_o, c1_o, top_o, tag_empty_o, underflow_o, e.cc, e.top, e.pop, e.unf);
        end
      end
    end
  end

  task automatic op(input logic [7:0] opc, input logic [2:0] r, input logic [79:0] s,
                    input logic [1:0] t, input logic [31:0] iv, input logic [2:0] tp,
                    input logic [2:0] ecc, input logic eunf, input string req);
    exp_t e;
    e.cc = ecc; e.unf = eunf; e.pop = (r == 3'd3);
    e.top = e.pop ? tp + 3'd1 : tp;
    e.req = req;
    @(negedge clk);
    sb_q.push_back(e);
    opcode = opc; rg = r; st0 = s; tag = t; ival = iv; top = tp; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
  endtask

  task automatic none(input logic [7:0] opc, input logic [2:0] r, input string req);
    @(negedge clk);
    opcode = opc; rg = r; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    n_chk++;
    if (done_o !== 1'b0) begin
      n_fail++;
      $display("FAIL %s: actual done=%b expected done=0", req, done_o);
    end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [79:0] five, six, one, m32k, m2g, p2g1, pinf, ninf;
    five = xr(0, 15'h4001, 64'hA000_0000_0000_0000);
    six  = xr(0, 15'h4001, 64'hC000_0000_0000_0000);
    one  = xr(0, 15'h3FFF, 64'h8000_0000_0000_0000);
    m32k = xr(1, 15'h400E, 64'h8000_0000_0000_0000);
    m2g  = xr(1, 15'h401E, 64'h8000_0000_0000_0000);
    p2g1 = xr(0, 15'h401D, 64'hFFFF_FFFE_0000_0000);
    pinf = xr(0, 15'h7FFF, 64'h8000_0000_0000_0000);
    ninf = xr(1, 15'h7FFF, 64'h8000_0000_0000_0000);

    repeat (3) @(negedge clk);
    n_chk++;
    if ({done_o, tag_empty_o, top_o} !== 5'b0) begin
      n_fail++;
      $display("FAIL R9 reset: actual done=%b pop=%b top=%0d expected 0 0 0", done_o, tag_empty_o, top_o);
    end
    rst_n = 1'b1;

    // R1 / R2 exact conversion and codes
    op(8'hDE, 3'd2, five, 2'b00, 32'd5,         3'd1, 3'b100, 0, "R2 eq 5");
    op(8'hDE, 3'd2, five, 2'b00, 32'hABCD_0005, 3'd1, 3'b100, 0, "R1 narrow ignores upper");
    op(8'hDA, 3'd2, five, 2'b00, 32'd6,         3'd2, 3'b001, 0, "R2 lt 5<6");
    op(8'hDA, 3'd2, six,  2'b00, 32'd5,         3'd2, 3'b000, 0, "R2 gt 6>5");
    op(8'hDA, 3'd2, xr(0, 15'h4001, 64'hA000_0000_0000_0001), 2'b00, 32'd5, 3'd0, 3'b000, 0, "R2 adjacent above");
    op(8'hDA, 3'd2, xr(0, 15'h4001, 64'h9FFF_FFFF_FFFF_FFFF), 2'b00, 32'd5, 3'd0, 3'b001, 0, "R2 adjacent below");
    op(8'hDE, 3'd2, one,  2'b00, 32'hFFFF_FFFF, 3'd0, 3'b000, 0, "R2 1 > -1");
    op(8'hDE, 3'd2, m32k, 2'b00, 32'h0000_8000, 3'd0, 3'b100, 0, "R1 narrow min");
    op(8'hDA, 3'd2, m32k, 2'b00, 32'h0000_8000, 3'd0, 3'b001, 0, "R1 wide +32768");
    op(8'hDA, 3'd2, m2g,  2'b00, 32'h8000_0000, 3'd0, 3'b100, 0, "R1 wide min");
    op(8'hDA, 3'd2, p2g1, 2'b00, 32'h7FFF_FFFF, 3'd0, 3'b100, 0, "R1 wide max");
    // R4
    op(8'hDE, 3'd2, xr(1, 15'h0, 64'h0), 2'b00, 32'd0, 3'd0, 3'b100, 0, "R4 -0 == 0");
    op(8'hDA, 3'd2, xr(0, 15'h0, 64'h0), 2'b00, 32'd0, 3'd0, 3'b100, 0, "R4 +0 == 0");
    // R5
    op(8'hDA, 3'd2, pinf, 2'b00, 32'h7FFF_FFFF, 3'd0, 3'b000, 0, "R5 +inf");
    op(8'hDA, 3'd2, ninf, 2'b00, 32'h8000_0000, 3'd0, 3'b001, 0, "R5 -inf");
    op(8'hDA, 3'd2, xr(0, 15'h0, 64'h1), 2'b00, 32'd0, 3'd0, 3'b000, 0, "R5 denormal > 0");
    op(8'hDA, 3'd2, xr(1, 15'h0, 64'h1), 2'b00, 32'd0, 3'd0, 3'b001, 0, "R5 -denormal < 0");
    op(8'hDA, 3'd2, xr(0, 15'h0, 64'h8000_0000_0000_0000), 2'b00, 32'd1, 3'd0, 3'b001, 0, "R5 denormal < 1");
    // R3
    op(8'hDA, 3'd2, xr(0, 15'h7FFF, 64'hC000_0000_0000_0000), 2'b00, 32'd0, 3'd0, 3'b111, 0, "R3 quiet NaN");
    op(8'hDE, 3'd2, xr(1, 15'h7FFF, 64'h8000_0000_0000_0001), 2'b00, 32'd0, 3'd0, 3'b111, 0, "R3 signaling NaN");
    op(8'hDA, 3'd2, xr(0, 15'h4001, 64'h2000_0000_0000_0000), 2'b00, 32'd0, 3'd0, 3'b111, 0, "R3 unnormal");
    op(8'hDA, 3'd2, xr(0, 15'h7FFF, 64'h0), 2'b00, 32'd0, 3'd0, 3'b111, 0, "R3 pseudo-infinity");
    // R7
    op(8'hDA, 3'd2, five, 2'b11, 32'd5, 3'd4, 3'b111, 1, "R7 empty tag");
    // R6 / R8
    op(8'hDE, 3'd3, five, 2'b00, 32'd5, 3'd7, 3'b100, 0, "R6 pop wraps 7->0");
    op(8'hDA, 3'd3, six,  2'b00, 32'd5, 3'd3, 3'b000, 0, "R6 pop 3->4 R8");
    op(8'hDA, 3'd2, six,  2'b00, 32'd5, 3'd7, 3'b000, 0, "R6 no pop holds 7");
    // R9
    none(8'hD8, 3'd2, "R9 other opcode");
    none(8'hDE, 3'd0, "R9 other reg field");
    none(8'hDA, 3'd7, "R9 other reg field wide");

    repeat (3) @(negedge clk);
    n_chk++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R9 missing results: actual pending=%0d expected 0", sb_q.size());
    end
    finish_run();
  end
endmodule